// File: doc/BRIEF.md
# VGA Test Pattern Generator

This block produces the raster timing for a 640x480 display driven from a 25 MHz pixel clock. For every pixel it also produces an 8-bit red, green and blue value, which feeds an external resistor-ladder converter. Horizontal and vertical counters run continuously. Sync pulses and blanking flags are decoded from the counters. A pattern stage then turns the counter values into colour values. Every output comes from a register, so all outputs move together, one clock after the counter state they describe.

The pattern is chosen with an 8-bit selector on the data input. The block samples this selector on every clock edge while reset is held. After reset is released the choice is frozen and does not change until the next reset. In pass-through mode the data input goes straight to all three colour buses, so the same input serves as test data for the converters. Eight dedicated pins carry the two syncs and the top two bits of each colour, packed in a fixed order.

Top module: `vga_tpg_top`

## Requirements
- R1: While `rst` is high, each clock edge sets `hsync_n`, `vsync_n`, `hblank` and `vblank` to 1 and sets all colour buses to 0. Reset also clears the column, line and frame counters.
- R2: The selector is taken from `din` on every clock edge that has `rst` high. The value present at the last reset edge takes effect and is held, whatever `din` does afterwards.
- R3: At the output edge for column x, `hblank` is 1 exactly when x >= H_VIS. `hsync_n` is 0 exactly when H_VIS+H_FP <= x < H_VIS+H_FP+H_SYNC. The output edge for counter position p is edge p+1 after reset release.
- R4: At the output edge for line y, `vblank` is 1 exactly when y >= V_VIS. `vsync_n` is 0 exactly when V_VIS+V_FP <= y < V_VIS+V_FP+V_SYNC.
- R5: Selector 8'h10 selects the ramp pattern. Red is x mod 256, green is y mod 256, and blue is the frame count mod 256. The frame count steps by one when the counters wrap from the last pixel of the last line.
- R6: Selector 8'h30 selects the XOR pattern. Red is (x^y)[7:0], green is (x^y)[8:1], and blue is (x^y)[9:2].
- R7: Selector 8'h00 selects pass-through. All three colour buses show the `din` value from the previous edge, in both the visible and the blanked area.
- R8: In the ramp and XOR patterns, all colour buses are 0 whenever `hblank` or `vblank` is 1.
- R9: Any selector other than 8'h00 and 8'h30 selects the ramp pattern.
- R10: `pins` is packed as follows: [0]=red[7], [1]=green[7], [2]=blue[7], [3]=vsync_n, [4]=red[6], [5]=green[6], [6]=blue[6], [7]=hsync_n.
- R11: A reset applied in the middle of a frame restarts the counters at column 0, line 0 and frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset; the selector is sampled while it is high |
| din | input | 8 | Pattern selector during reset; pass-through data afterwards |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| hblank | output | 1 | High outside the visible columns |
| vblank | output | 1 | High outside the visible lines |
| red | output | 8 | Red value |
| green | output | 8 | Green value |
| blue | output | 8 | Blue value |
| pins | output | 8 | Packed syncs and top colour bits |

## Verification
Two things can happen on the same clock edge: the final selector capture and the first counting cycle. On the last reset edge, the bench drives one selector value. On the next edge it releases reset and drives a different value on `din` in the same cycle. It then checks that the first pixel and every later pixel follow the pattern from the last reset-edge value. Two other events also share an edge: the wrap to a new frame, which steps blue, and the end of vertical blanking. Runs of two frames check that blue is still 0 during blanking and shows the new count on the first visible pixel.

// File: rtl/vga_tpg_pkg.sv
package vga_tpg_pkg;

  typedef enum logic [1:0] {
    PAT_PASS = 2'd0,
    PAT_RAMP = 2'd1,
    PAT_XOR  = 2'd2
  } pat_e;

  localparam logic [7:0] SEL_PASS = 8'h00;
  localparam logic [7:0] SEL_RAMP = 8'h10;
  localparam logic [7:0] SEL_XOR  = 8'h30;

  localparam int NUM_CH = 3;

endpackage

// File: rtl/vga_tpg_mode.sv
module vga_tpg_mode
  import vga_tpg_pkg::*;
#(
  parameter int SEL_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel_in,
  output pat_e             mode
);

  localparam logic [SEL_W-1:0] K_PASS = SEL_W'(SEL_PASS);
  localparam logic [SEL_W-1:0] K_XOR  = SEL_W'(SEL_XOR);

  pat_e decoded;

  always_comb begin
    if (sel_in == K_PASS)     decoded = PAT_PASS;
    else if (sel_in == K_XOR) decoded = PAT_XOR;
    else                      decoded = PAT_RAMP;
  end

  // keep sampling while reset is held; freeze afterwards
  always_ff @(posedge clk) begin
    if (rst) mode <= decoded;
  end

endmodule

// File: rtl/vga_tpg_timing.sv
module vga_tpg_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int CW     = 10,
  parameter int FW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] hcnt,
  output logic [CW-1:0] vcnt,
  output logic [FW-1:0] frame,
  output logic          h_vis,
  output logic          v_vis,
  output logic          h_sync,
  output logic          v_sync
);

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int H_SS  = H_VIS + H_FP;
  localparam int H_SE  = H_SS + H_SYNC;
  localparam int V_SS  = V_VIS + V_FP;
  localparam int V_SE  = V_SS + V_SYNC;

  logic h_last, v_last;

  assign h_last = (hcnt == CW'(H_TOT - 1));
  assign v_last = (vcnt == CW'(V_TOT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      vcnt  <= '0;
      frame <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      if (v_last) begin
        vcnt  <= '0;
        frame <= frame + 1'b1;
      end else begin
        vcnt <= vcnt + 1'b1;
      end
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  assign h_vis  = (hcnt < CW'(H_VIS));
  assign v_vis  = (vcnt < CW'(V_VIS));
  assign h_sync = (hcnt >= CW'(H_SS)) && (hcnt < CW'(H_SE));
  assign v_sync = (vcnt >= CW'(V_SS)) && (vcnt < CW'(V_SE));

endmodule

// File: rtl/vga_tpg_pattern.sv
module vga_tpg_pattern
  import vga_tpg_pkg::*;
#(
  parameter int CW    = 10,
  parameter int COL_W = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  pat_e                           mode,
  input  logic [COL_W-1:0]               din,
  input  logic [CW-1:0]                  hcnt,
  input  logic [CW-1:0]                  vcnt,
  input  logic [COL_W-1:0]               frame,
  input  logic                           h_vis,
  input  logic                           v_vis,
  input  logic                           h_sync,
  input  logic                           v_sync,
  output logic                           hsync_n,
  output logic                           vsync_n,
  output logic                           hblank,
  output logic                           vblank,
  output logic [NUM_CH-1:0][COL_W-1:0]   col
);

  logic visible;
  assign visible = h_vis && v_vis;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [COL_W-1:0] xr;
    logic [COL_W-1:0] rp;
    logic [COL_W-1:0] nx;

    // each channel takes a slice shifted by its index
    assign xr = hcnt[ch +: COL_W] ^ vcnt[ch +: COL_W];

    if (ch == 0) begin : g_rp_x
      assign rp = hcnt[COL_W-1:0];
    end else if (ch == 1) begin : g_rp_y
      assign rp = vcnt[COL_W-1:0];
    end else begin : g_rp_f
      assign rp = frame;
    end

    always_comb begin
      unique case (mode)
        PAT_PASS: nx = din;
        PAT_XOR:  nx = visible ? xr : '0;
        default:  nx = visible ? rp : '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (rst) col[ch] <= '0;
      else     col[ch] <= nx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
      hblank  <= 1'b1;
      vblank  <= 1'b1;
    end else begin
      hsync_n <= ~h_sync;
      vsync_n <= ~v_sync;
      hblank  <= ~h_vis;
      vblank  <= ~v_vis;
    end
  end

endmodule

// File: rtl/vga_tpg_top.sv
module vga_tpg_top
  import vga_tpg_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int COL_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [COL_W-1:0] din,
  output logic             hsync_n,
  output logic             vsync_n,
  output logic             hblank,
  output logic             vblank,
  output logic [COL_W-1:0] red,
  output logic [COL_W-1:0] green,
  output logic [COL_W-1:0] blue,
  output logic [7:0]       pins
);

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int T_MAX = (H_TOT > V_TOT) ? H_TOT : V_TOT;
  localparam int CW0   = $clog2(T_MAX);
  // XOR slices reach NUM_CH-1 bits above the colour width
  localparam int CW    = (CW0 > COL_W + NUM_CH - 1) ? CW0 : COL_W + NUM_CH - 1;

  pat_e                         mode_q;
  logic [CW-1:0]                hcnt, vcnt;
  logic [COL_W-1:0]             frame;
  logic                         h_vis, v_vis, h_sync, v_sync;
  logic [NUM_CH-1:0][COL_W-1:0] col;

  vga_tpg_mode #(.SEL_W(COL_W)) u_mode (
    .clk    (clk),
    .rst    (rst),
    .sel_in (din),
    .mode   (mode_q)
  );

  vga_tpg_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .CW(CW), .FW(COL_W)
  ) u_timing (
    .clk    (clk),
    .rst    (rst),
    .hcnt   (hcnt),
    .vcnt   (vcnt),
    .frame  (frame),
    .h_vis  (h_vis),
    .v_vis  (v_vis),
    .h_sync (h_sync),
    .v_sync (v_sync)
  );

  vga_tpg_pattern #(.CW(CW), .COL_W(COL_W)) u_pattern (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .din     (din),
    .hcnt    (hcnt),
    .vcnt    (vcnt),
    .frame   (frame),
    .h_vis   (h_vis),
    .v_vis   (v_vis),
    .h_sync  (h_sync),
    .v_sync  (v_sync),
    .hsync_n (hsync_n),
    .vsync_n (vsync_n),
    .hblank  (hblank),
    .vblank  (vblank),
    .col     (col)
  );

  assign red   = col[0];
  assign green = col[1];
  assign blue  = col[2];

  assign pins = {hsync_n, blue[COL_W-2], green[COL_W-2], red[COL_W-2],
                 vsync_n, blue[COL_W-1], green[COL_W-1], red[COL_W-1]};

endmodule

// File: rtl/vga_tpg_chk.sv
module vga_tpg_chk
  import vga_tpg_pkg::*;
#(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [COL_W-1:0] din,
  input logic             hsync_n,
  input logic             vsync_n,
  input logic             hblank,
  input logic             vblank,
  input logic [COL_W-1:0] red,
  input logic [COL_W-1:0] green,
  input logic [COL_W-1:0] blue,
  input pat_e             mode_q
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (hsync_n && vsync_n && hblank && vblank &&
             red == '0 && green == '0 && blue == '0));

  assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q));

  assert_hsync_in_blank_R3: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> hblank);

  assert_vsync_in_blank_R4: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> vblank);

  assert_pass_follow_R7: assert property (@(posedge clk) disable iff (rst)
    (mode_q == PAT_PASS) |=> (red == $past(din) && green == $past(din) &&
                              blue == $past(din)));

  assert_blank_black_R8: assert property (@(posedge clk) disable iff (rst)
    (mode_q != PAT_PASS && (hblank || vblank)) |->
      (red == '0 && green == '0 && blue == '0));

endmodule

bind vga_tpg_top vga_tpg_chk #(.COL_W(COL_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .hsync_n (hsync_n),
  .vsync_n (vsync_n),
  .hblank  (hblank),
  .vblank  (vblank),
  .red     (red),
  .green   (green),
  .blue    (blue),
  .mode_q  (mode_q)
);

// File: tb/vga_tpg_top_tb.sv
module vga_tpg_top_tb;

  localparam int H_VIS = 260, H_FP = 4, H_SYNC = 8, H_BP = 8;
  localparam int V_VIS = 4,   V_FP = 1, V_SYNC = 2, V_BP = 1;
  localparam int HT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int VT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int FRAME = HT * VT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = 8'h00;
  logic       hsync_n, vsync_n, hblank, vblank;
  logic [7:0] red, green, blue, pins;

  vga_tpg_top #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .COL_W(8)
  ) u_dut (
    .clk(clk), .rst(rst), .din(din),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .hblank(hblank), .vblank(vblank),
    .red(red), .green(green), .blue(blue), .pins(pins)
  );

  always #5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  int n = 0;      // counting edges since the last reset edge
  int mm = 1;     // model mode: 0 pass, 1 ramp, 2 xor
  bit done = 0;

  logic       e_hs, e_vs, e_hb, e_vb;
  logic [7:0] e_r, e_g, e_b;
  string      e_ctag, e_htag, e_vtag;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // drive one cycle, predict the result of the next edge, check it at the next negedge
  task automatic step(input logic r, input logic [7:0] d, input string tag);
    int p, x, y, f;
    bit vis;
    rst = r;
    din = d;
    if (r) begin
      mm = (d == 8'h00) ? 0 : (d == 8'h30) ? 2 : 1;
      n = 0;
      e_hs = 1; e_vs = 1; e_hb = 1; e_vb = 1;
      e_r = 0; e_g = 0; e_b = 0;
      e_ctag = "R1"; e_htag = "R1"; e_vtag = "R1";
    end else begin
      p = n;
      n++;
      x = p % HT;
      y = (p / HT) % VT;
      f = (p / FRAME) % 256;
      e_hb = (x >= H_VIS);
      e_vb = (y >= V_VIS);
      e_hs = !((x >= H_VIS + H_FP) && (x < H_VIS + H_FP + H_SYNC));
      e_vs = !((y >= V_VIS + V_FP) && (y < V_VIS + V_FP + V_SYNC));
      vis = !e_hb && !e_vb;
      e_htag = "R3"; e_vtag = "R4";
      if (mm == 0) begin
        e_r = d; e_g = d; e_b = d; e_ctag = "R7";
      end else if (!vis) begin
        e_r = 0; e_g = 0; e_b = 0; e_ctag = "R8";
      end else if (mm == 2) begin
        e_r = 8'((x ^ y));
        e_g = 8'(((x >> 1) ^ (y >> 1)));
        e_b = 8'(((x >> 2) ^ (y >> 2)));
        e_ctag = "R6";
      end else begin
        e_r = 8'(x); e_g = 8'(y); e_b = 8'(f); e_ctag = "R5";
      end
      if (tag != "") e_ctag = tag;
    end
    @(negedge clk);
    chk(hsync_n == e_hs, e_htag, "hsync_n", hsync_n, e_hs);
    chk(hblank  == e_hb, e_htag, "hblank",  hblank,  e_hb);
    chk(vsync_n == e_vs, e_vtag, "vsync_n", vsync_n, e_vs);
    chk(vblank  == e_vb, e_vtag, "vblank",  vblank,  e_vb);
    chk(red   == e_r, e_ctag, "red",   red,   e_r);
    chk(green == e_g, e_ctag, "green", green, e_g);
    chk(blue  == e_b, e_ctag, "blue",  blue,  e_b);
    chk(pins == {e_hs, e_b[6], e_g[6], e_r[6], e_vs, e_b[7], e_g[7], e_r[7]},
        "R10", "pins", pins,
        {e_hs, e_b[6], e_g[6], e_r[6], e_vs, e_b[7], e_g[7], e_r[7]});
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) step(1'b1, 8'(8'h5A + i), "R1");
  endtask

  // R2: last reset-edge value wins; din changes on release cycle and later
  task automatic t_ramp;
    step(1'b1, 8'h30, "");
    step(1'b1, 8'h00, "");
    step(1'b1, 8'h10, "");
    for (int i = 0; i < 300; i++) step(1'b0, (i == 0) ? 8'h30 : 8'(i * 7), "R2");
    for (int i = 300; i < 2 * FRAME + 60; i++) step(1'b0, 8'(i), "");
  endtask

  task automatic t_xor;
    step(1'b1, 8'h10, "");
    step(1'b1, 8'h30, "");
    for (int i = 0; i < FRAME + 40; i++) step(1'b0, 8'(i * 3), "");
  endtask

  task automatic t_pass;
    step(1'b1, 8'h00, "");
    for (int i = 0; i < 2 * HT + 40; i++) step(1'b0, 8'((i * 37) ^ (i >> 2)), "");
  endtask

  task automatic t_unknown;
    step(1'b1, 8'h77, "R9");
    for (int i = 0; i < 2 * HT; i++) step(1'b0, 8'h00, (mm == 1 && n > 0) ? "" : "R9");
    step(1'b1, 8'h31, "R9");
    for (int i = 0; i < HT + 20; i++) step(1'b0, 8'hFF, "R9");
  endtask

  task automatic t_midreset;
    step(1'b1, 8'h10, "");
    for (int i = 0; i < FRAME + 3 * HT + 17; i++) step(1'b0, 8'h00, "");
    step(1'b1, 8'h22, "R11");
    step(1'b1, 8'h10, "R11");
    for (int i = 0; i < 2 * HT; i++) step(1'b0, 8'h00, "R11");
  endtask

  initial begin
    #(10 * 190000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_ramp();
    t_xor();
    t_pass();
    t_unknown();
    t_midreset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule